// File: doc/BRIEF.md
# Cell Balancing Configuration Register with Communication Watchdog

This block stores the configuration word that a host writes through an upstream serial decoder. The stored word drives one discharge-switch enable per cell, the pull-down enables of two open-drain general-purpose pins, and a requested operating mode (standby or measure). The block takes no action on its own. Each discharge switch, pin and mode follows only what the host last wrote.

A communication watchdog counts clock cycles since the last valid command. If the host goes quiet for `TIMEOUT_CYCLES` cycles, the active-low watchdog flag drops. While the flag is low, the configuration is held at its safe default: every discharge switch is off, both pins are released and the mode is standby. Readback returns the stored word, but the two pin bits are replaced by the pin levels actually sampled. A pin that is pulled down therefore always reads 0, and a released pin reads whatever the outside world drives.

Top module: `cell_cfg_guard`

## Requirements
- R1: After reset is released, `wdtN` is 1. It goes to 0 at exactly the `TIMEOUT_CYCLES`-th rising edge after reset release, or after the last edge at which `cmdValid` was sampled high, provided `cmdValid` was not high in between.
- R2: An edge at which `cmdValid` is sampled high restarts the timeout window and leaves `wdtN` at 1 after that edge. Pulses spaced closer than `TIMEOUT_CYCLES` edges keep `wdtN` at 1 indefinitely.
- R3: While `wdtN` is 0, the configuration equals the default: `dischargeEn` all 0, `gpioPullDown` 2'b00 and `measureMode` 0. A write with `wrEn` high and `cmdValid` low is ignored in this state.
- R4: If `wrEn` is high at the very edge where `wdtN` falls, the register still ends in the default state.
- R5: An edge with `wrEn` high loads `wrData` into the register. The field layout is: bits [NUM_CELLS-1:0] are the discharge enables (bit i is cell i). Bit NUM_CELLS is pin 0 control and bit NUM_CELLS+1 is pin 1 control. Bit NUM_CELLS+2 is the mode bit (1 = measure). A write together with `cmdValid` is accepted even while `wdtN` is 0.
- R6: `gpioPullDown[i]` is 1 when the stored pin-i control bit is 0 (pin pulled low). It is 0 when the bit is 1 (pin released).
- R7: `cfgRead` returns the stored word, except that the two pin bits show the live `gpioPin` levels instead of the stored bits.
- R8: Out of reset the register holds the default: all discharge enables 0, both pin bits 1 and `measureMode` 0 (standby). Measure mode is entered only by a write with the mode bit set.
- R9: `dischargeEn` changes only at a write edge or at watchdog expiry. A `cmdValid` pulse without `wrEn` leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Configuration write strobe |
| wrData | input | NUM_CELLS+3 | Configuration word to write |
| cmdValid | input | 1 | One-cycle pulse per valid host command |
| gpioPin | input | 2 | Sampled levels of the two general-purpose pins |
| dischargeEn | output | NUM_CELLS | Per-cell discharge switch enables |
| gpioPullDown | output | 2 | Open-drain pull-down enables for the two pins |
| cfgRead | output | NUM_CELLS+3 | Configuration readback with live pin levels |
| wdtN | output | 1 | Watchdog flag, 0 when the host has timed out |
| measureMode | output | 1 | Requested mode, 1 = measure, 0 = standby |

## Verification
The hardest case to reach is the collision in which a write lands on the exact edge where the timeout completes. Missing that edge by one cycle either way turns the test into a plain write or a plain ignored write. The bench reaches the edge by pulsing `cmdValid` once, stepping exactly `TIMEOUT_CYCLES-1` edges, and raising `wrEn` for the single following edge. It uses a reduced timeout so the window stays short. The open-drain pins are modelled in the bench, so readback is checked against both a pulled-down pin and a released pin driven high or low from outside.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

  typedef enum logic {
    MODE_STANDBY = 1'b0,
    MODE_MEASURE = 1'b1
  } op_mode_e;

  typedef struct packed {
    logic load;
    logic clear;
  } cfg_strobe_t;

endpackage

// File: rtl/cfg_guard_ctrl.sv
module cfg_guard_ctrl
  import cfg_guard_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1500
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        cmdValid,
  output cfg_strobe_t strobe,
  output logic        wdtN
);

  localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] idleCnt;
  logic             expiredQ;
  logic             atLimit;

  assign atLimit = (idleCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt  <= '0;
      expiredQ <= 1'b0;
    end else if (cmdValid) begin
      idleCnt  <= '0;
      expiredQ <= 1'b0;
    end else begin
      if (!atLimit) idleCnt <= idleCnt + 1'b1;
      else          expiredQ <= 1'b1;
    end
  end

  // The counter saturates at LAST, so the clear persists for as long as the timeout lasts.
  always_comb begin
    strobe.clear = !cmdValid && atLimit;
    strobe.load  = wrEn;
  end

  assign wdtN = !expiredQ;

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= LAST);

  p_expire_edge_r1: assert property (@(posedge clk) disable iff (!rstN)
    (atLimit && !cmdValid) |=> !wdtN);

  p_kick_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (wdtN && idleCnt == '0));

endmodule

// File: rtl/cfg_guard_dp.sv
module cfg_guard_dp
  import cfg_guard_pkg::*;
#(
  parameter int NUM_CELLS = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfg_strobe_t          strobe,
  input  logic [NUM_CELLS+2:0] wrData,
  input  logic [1:0]           gpioPin,
  output logic [NUM_CELLS-1:0] dischargeEn,
  output logic [1:0]           gpioPullDown,
  output logic [NUM_CELLS+2:0] cfgRead,
  output logic                 measureMode
);

  localparam int CFG_W   = NUM_CELLS + 3;
  localparam int GPIO_LO = NUM_CELLS;
  localparam int MODE_B  = NUM_CELLS + 2;
  localparam logic [CFG_W-1:0] CFG_DEFAULT =
    {MODE_STANDBY, 2'b11, {NUM_CELLS{1'b0}}};

  logic [CFG_W-1:0] cfgQ;
  op_mode_e         modeNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cfgQ <= CFG_DEFAULT;
    else if (strobe.clear) cfgQ <= CFG_DEFAULT;
    else if (strobe.load)  cfgQ <= wrData;
  end

  assign modeNow = op_mode_e'(cfgQ[MODE_B]);

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_pin
      assign gpioPullDown[g]      = !cfgQ[GPIO_LO+g];
      assign cfgRead[GPIO_LO+g]   = gpioPin[g];
    end
  endgenerate

  assign dischargeEn              = cfgQ[NUM_CELLS-1:0];
  assign measureMode              = (modeNow == MODE_MEASURE);
  assign cfgRead[NUM_CELLS-1:0]   = cfgQ[NUM_CELLS-1:0];
  assign cfgRead[MODE_B]          = cfgQ[MODE_B];

  p_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.clear) |=> (cfgQ == $past(wrData)));

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (cfgQ == CFG_DEFAULT));

endmodule

// File: rtl/cell_cfg_guard.sv
module cell_cfg_guard
  import cfg_guard_pkg::*;
#(
  parameter int NUM_CELLS      = 12,
  parameter int TIMEOUT_CYCLES = 1500
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [NUM_CELLS+2:0] wrData,
  input  logic                 cmdValid,
  input  logic [1:0]           gpioPin,
  output logic [NUM_CELLS-1:0] dischargeEn,
  output logic [1:0]           gpioPullDown,
  output logic [NUM_CELLS+2:0] cfgRead,
  output logic                 wdtN,
  output logic                 measureMode
);

  cfg_strobe_t strobe;

  cfg_guard_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .cmdValid (cmdValid),
    .strobe   (strobe),
    .wdtN     (wdtN)
  );

  cfg_guard_dp #(.NUM_CELLS(NUM_CELLS)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (wrData),
    .gpioPin      (gpioPin),
    .dischargeEn  (dischargeEn),
    .gpioPullDown (gpioPullDown),
    .cfgRead      (cfgRead),
    .measureMode  (measureMode)
  );

  p_safe_while_wdt_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wdtN |-> (dischargeEn == '0 && gpioPullDown == 2'b00 && !measureMode));

  p_discharge_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(dischargeEn) || (!wdtN && dischargeEn == '0)));

endmodule

// File: tb/test_cell_cfg_guard.sv
module test_cell_cfg_guard;

  localparam int  NC       = 12;
  localparam int  TO       = 40;
  localparam int  W        = NC + 3;
  localparam time CLK_PER  = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [W-1:0]  wrData = '0;
  logic          cmdValid = 1'b0;
  logic [1:0]    extLvl = 2'b11;
  logic [1:0]    gpioPin;
  logic [NC-1:0] dischargeEn;
  logic [1:0]    gpioPullDown;
  logic [W-1:0]  cfgRead;
  logic          wdtN;
  logic          measureMode;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  // open-drain pin model: a pulled-down pin reads 0, a released pin reads the outside level
  always_comb
    for (int i = 0; i < 2; i++) gpioPin[i] = gpioPullDown[i] ? 1'b0 : extLvl[i];

  cell_cfg_guard #(.NUM_CELLS(NC), .TIMEOUT_CYCLES(TO)) i_cell_cfg_guard (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .cmdValid(cmdValid),
    .gpioPin(gpioPin), .dischargeEn(dischargeEn), .gpioPullDown(gpioPullDown),
    .cfgRead(cfgRead), .wdtN(wdtN), .measureMode(measureMode)
  );

  function automatic logic [W-1:0] mkCfg(logic mode, logic [1:0] pins, logic [NC-1:0] dis);
    return {mode, pins, dis};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic kick();
    cmdValid = 1'b1;
    step();
    cmdValid = 1'b0;
  endtask

  task automatic checkDefault(string req);
    check(req, "dischargeEn", 32'(dischargeEn), 0);
    check(req, "gpioPullDown", 32'(gpioPullDown), 0);
    check(req, "measureMode", 32'(measureMode), 0);
  endtask

  task automatic t_reset();
    extLvl = 2'b11;
    #1;
    check("R8", "wdtN after reset", 32'(wdtN), 1);
    checkDefault("R8");
    check("R8", "cfgRead after reset", 32'(cfgRead), 32'(mkCfg(1'b0, 2'b11, '0)));
  endtask

  task automatic t_write();
    wrData = mkCfg(1'b1, 2'b01, 12'hA5C);
    wrEn = 1'b1; cmdValid = 1'b1;
    step();
    wrEn = 1'b0; cmdValid = 1'b0;
    check("R5", "dischargeEn after write", 32'(dischargeEn), 32'h A5C);
    check("R8", "measureMode after write", 32'(measureMode), 1);
    check("R6", "gpioPullDown bits 01", 32'(gpioPullDown), 32'b10);
    check("R7", "cfgRead pins ext=11", 32'(cfgRead), 32'(mkCfg(1'b1, 2'b01, 12'hA5C)));
    extLvl = 2'b00; #1;
    check("R7", "cfgRead pins ext=00", 32'(cfgRead), 32'(mkCfg(1'b1, 2'b00, 12'hA5C)));
    extLvl = 2'b11;
  endtask

  task automatic t_hold();
    kick();
    check("R9", "dischargeEn after lone cmdValid", 32'(dischargeEn), 32'hA5C);
    wrData = mkCfg(1'b0, 2'b10, 12'h3F1);
    wrEn = 1'b1;
    step();
    wrEn = 1'b0;
    check("R5", "dischargeEn plain write", 32'(dischargeEn), 32'h3F1);
    check("R6", "gpioPullDown bits 10", 32'(gpioPullDown), 32'b01);
    check("R8", "measureMode cleared by write", 32'(measureMode), 0);
  endtask

  task automatic t_timeout();
    kick();
    repeat (TO - 1) step();
    check("R1", "wdtN one edge before timeout", 32'(wdtN), 1);
    check("R9", "dischargeEn held while idle", 32'(dischargeEn), 32'h3F1);
    step();
    check("R1", "wdtN at timeout", 32'(wdtN), 0);
    checkDefault("R3");
    wrData = mkCfg(1'b1, 2'b00, 12'hFFF);
    wrEn = 1'b1;
    step();
    wrEn = 1'b0;
    checkDefault("R3");
    check("R3", "wdtN still low", 32'(wdtN), 0);
  endtask

  task automatic t_reload();
    kick();
    check("R2", "wdtN after kick", 32'(wdtN), 1);
    for (int k = 0; k < 4; k++) begin
      repeat (TO - 2) step();
      kick();
    end
    repeat (TO - 1) step();
    check("R2", "wdtN with kicks inside window", 32'(wdtN), 1);
    step();
    check("R1", "wdtN after last kick window", 32'(wdtN), 0);
  endtask

  task automatic t_collide();
    wrData = mkCfg(1'b1, 2'b00, 12'h0F0);
    wrEn = 1'b1; cmdValid = 1'b1;
    step();
    wrEn = 1'b0; cmdValid = 1'b0;
    check("R5", "write with cmdValid while expired", 32'(dischargeEn), 32'h0F0);
    check("R2", "wdtN released by write command", 32'(wdtN), 1);
    repeat (TO - 1) step();
    wrData = mkCfg(1'b1, 2'b00, 12'hFFF);
    wrEn = 1'b1;
    step();
    wrEn = 1'b0;
    check("R4", "wdtN at colliding edge", 32'(wdtN), 0);
    checkDefault("R4");
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    t_reset();
    t_write();
    t_hold();
    t_timeout();
    t_reload();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule